// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Twenty-one level-held source flags are merged into ten vector slots. Each slot has one software level bit, which places it either in the low level or in its upper level. The first two slots may be raised to the top level. The other eight may only reach the middle level. Among the pending slots, the block picks the one at the highest level, and on a tie the one at the lowest slot number.

The block keeps the level currently being serviced. A winner is accepted only when the global enable is set and its level is strictly above that service level. On acceptance the block registers the slot's vector address, pulses an acknowledge for one cycle, saves the old service level on a short stack and raises the service level to the winner's level. A return strobe from the core pops the saved level back. The block never clears source flags; the handler clears them at the peripheral.

Top module: `icu_nest_top`

## Requirements
- R1: After reset, `irq_ack` is 0, `irq_vec` is 0 and `cur_level` is 0 (nothing in service).
- R2: The vector address of slot k (k = 0..9) is 8*k + 3, giving 03h, 0Bh, ... 4Bh.
- R3: When several slots are pending at different levels, the slot with the highest level is the one presented.
- R4: When several pending slots share the highest level, the lowest-numbered slot is presented.
- R5: The level encoding on `cur_level` is 0 none, 1 low, 2 high, 3 top. `lvl_sel[k]`=0 puts slot k at low (1). `lvl_sel[k]`=1 puts slots 0 and 1 at top (3) and slots 2..9 at high (2).
- R6: A winner whose level is equal to or below `cur_level` is not accepted: `irq_ack` stays 0, and `cur_level` and `irq_vec` do not change.
- R7: A winner whose level is strictly above `cur_level` is accepted while another level is in service (nesting). One cycle later, `irq_ack` is 1 for that cycle, `irq_vec` carries its address and `cur_level` equals its level.
- R8: A `reti` pulse restores the level that was in service before the most recent acceptance. With nothing saved, `cur_level` becomes 0.
- R9: While `gie` is 0, no request is accepted.
- R10: `irq_vec` holds its value between acceptances. `irq_ack` is 1 only in the cycle after an accepting cycle.
- R11: Sources map to slots in consecutive groups of sizes 1,1,3,2,1,2,2,3,3,3: slot 0 = bit 0, slot 1 = bit 1, slot 2 = bits 2..4, slot 3 = bits 5..6, slot 4 = bit 7, slot 5 = bits 8..9, slot 6 = bits 10..11, slot 7 = bits 12..14, slot 8 = bits 15..17, slot 9 = bits 18..20. Any set bit of a group makes its slot pending.
- R12: When `reti` and an acceptable request occur in the same cycle, the return is performed and the request is not accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_flags | input | 21 | Level-held request flags from the sources |
| lvl_sel | input | 10 | Per-slot level choice, 1 = upper level |
| gie | input | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_ack | output | 1 | One-cycle acceptance pulse |
| irq_vec | output | 8 | Address of the last accepted vector |
| cur_level | output | 2 | Level currently in service |

## Verification
A corrupted service level or stack entry shows up on `cur_level` in the cycle after the acceptance or return that wrote it. It also changes whether later requests raise `irq_ack`. A wrong arbitration shows up as a wrong `irq_vec` one cycle after the request is first acceptable. The bench therefore compares the acknowledge, the vector and the level after every cycle against a reference model. The random mix of returns and nested requests drives the stack through all of its depths.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_e;

  // Number of sources merged into slot v.
  function automatic int unsigned grp_cnt(input int unsigned v);
    case (v)
      0, 1, 4: return 1;
      3, 5, 6: return 2;
      default: return 3;
    endcase
  endfunction

  // First source index of slot v (also total count when v == number of slots).
  function automatic int unsigned grp_lo(input int unsigned v);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < v; i++) acc += grp_cnt(i);
    return acc;
  endfunction

endpackage

// File: rtl/icu_src_merge.sv
module icu_src_merge #(
  parameter int unsigned NUM_VEC = 10,
  localparam int unsigned NUM_SRC = icu_pkg::grp_lo(NUM_VEC)
) (
  input  logic [NUM_SRC-1:0] src_flags,
  output logic [NUM_VEC-1:0] vec_pend
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_slot
    localparam int unsigned LO  = icu_pkg::grp_lo(v);
    localparam int unsigned CNT = icu_pkg::grp_cnt(v);
    assign vec_pend[v] = |src_flags[LO +: CNT];
  end
endmodule

// File: rtl/icu_prio_sel.sv
module icu_prio_sel
  import icu_pkg::*;
#(
  parameter int unsigned NUM_VEC   = 10,
  parameter int unsigned TOP_SLOTS = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] vec_pend,
  input  logic [NUM_VEC-1:0] lvl_sel,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_e               win_lvl
);
  lvl_e slot_lvl [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
    localparam lvl_e UPPER = (v < TOP_SLOTS) ? LVL_TOP : LVL_HIGH;
    assign slot_lvl[v] = !vec_pend[v] ? LVL_NONE :
                         (lvl_sel[v] ? UPPER : LVL_LOW);
  end

  // Scan upward and replace only on a strictly higher level: lowest slot wins ties.
  always_comb begin
    win_idx = '0;
    win_lvl = LVL_NONE;
    for (int unsigned v = 0; v < NUM_VEC; v++) begin
      if (slot_lvl[v] > win_lvl) begin
        win_lvl = slot_lvl[v];
        win_idx = IDX_W'(v);
      end
    end
  end
endmodule

// File: rtl/icu_level_stack.sv
module icu_level_stack
  import icu_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_en,
  input  lvl_e push_lvl,
  input  logic pop_en,
  output lvl_e cur_lvl
);
  lvl_e            stk_q [DEPTH];
  lvl_e            stk_d [DEPTH];
  logic [SP_W-1:0] sp_q, sp_d;
  lvl_e            cur_q, cur_d;

  always_comb begin
    sp_d  = sp_q;
    cur_d = cur_q;
    for (int unsigned i = 0; i < DEPTH; i++) stk_d[i] = stk_q[i];
    if (pop_en) begin
      if (sp_q != '0) begin
        cur_d = stk_q[sp_q - 1'b1];
        sp_d  = sp_q - 1'b1;
      end else begin
        cur_d = LVL_NONE;
      end
    end else if (push_en) begin
      if (sp_q < SP_W'(DEPTH)) begin
        stk_d[sp_q] = cur_q;
        sp_d        = sp_q + 1'b1;
      end
      cur_d = push_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cur_q <= LVL_NONE;
      for (int unsigned i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
    end else if (push_en || pop_en) begin
      sp_q  <= sp_d;
      cur_q <= cur_d;
      for (int unsigned i = 0; i < DEPTH; i++) stk_q[i] <= stk_d[i];
    end
  end

  assign cur_lvl = cur_q;
endmodule

// File: rtl/icu_nest_top.sv
module icu_nest_top
  import icu_pkg::*;
#(
  parameter int unsigned NUM_VEC     = 10,
  parameter int unsigned TOP_SLOTS   = 2,
  parameter int unsigned STACK_DEPTH = 3,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STEP    = 8,
  localparam int unsigned NUM_SRC    = icu_pkg::grp_lo(NUM_VEC),
  localparam int unsigned IDX_W      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_flags,
  input  logic [NUM_VEC-1:0] lvl_sel,
  input  logic               gie,
  input  logic               reti,
  output logic               irq_ack,
  output logic [ADDR_W-1:0]  irq_vec,
  output logic [1:0]         cur_level
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_VEC-1:0] vec_pend;
  logic [IDX_W-1:0]   win_idx;
  lvl_e               win_lvl;
  lvl_e               svc_lvl;
  logic               accept;
  logic [ADDR_W-1:0]  win_addr;

  icu_src_merge #(.NUM_VEC(NUM_VEC)) u_merge (
    .src_flags (src_flags),
    .vec_pend  (vec_pend)
  );

  icu_prio_sel #(.NUM_VEC(NUM_VEC), .TOP_SLOTS(TOP_SLOTS)) u_sel (
    .vec_pend (vec_pend),
    .lvl_sel  (lvl_sel),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  // Return has precedence over a new acceptance in the same cycle.
  assign accept   = gie && !reti && (win_lvl > svc_lvl);
  assign win_addr = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);

  icu_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .push_en  (accept),
    .push_lvl (win_lvl),
    .pop_en   (reti),
    .cur_lvl  (svc_lvl)
  );

  logic              ack_q, ack_d;
  logic [ADDR_W-1:0] vec_q, vec_d;

  always_comb begin
    ack_d = accept;
    vec_d = accept ? win_addr : vec_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (accept) vec_q <= vec_d;
    end
  end

  assign irq_ack   = ack_q;
  assign irq_vec   = vec_q;
  assign cur_level = svc_lvl;
endmodule

// File: rtl/icu_nest_chk.sv
module icu_nest_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned VEC_BASE  = 3,
  parameter int unsigned VEC_STEP  = 8,
  parameter int unsigned TOP_SLOTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              reti,
  input logic              irq_ack,
  input logic [ADDR_W-1:0] irq_vec,
  input logic [1:0]        cur_level
);
  localparam int unsigned TOP_LIMIT = VEC_BASE + VEC_STEP * TOP_SLOTS;

  a_r9_ack_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(gie));

  a_r12_reti_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !irq_ack);

  a_r7_ack_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (cur_level > $past(cur_level)));

  a_r8_reti_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> ((cur_level < $past(cur_level)) || (cur_level == 2'd0)));

  a_r2_addr_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ((int'(irq_vec) - int'(VEC_BASE)) % int'(VEC_STEP) == 0));

  a_r5_top_slots_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && cur_level == 2'd3) |-> (int'(irq_vec) < int'(TOP_LIMIT)));

  a_r10_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |-> $stable(irq_vec));
endmodule

bind icu_nest_top icu_nest_chk #(
  .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .TOP_SLOTS(TOP_SLOTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .gie       (gie),
  .reti      (reti),
  .irq_ack   (irq_ack),
  .irq_vec   (irq_vec),
  .cur_level (cur_level)
);

// File: tb/icu_nest_top_bench.sv
module icu_nest_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int NS = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_flags = '0;
  logic [NV-1:0] lvl_sel = '0;
  logic          gie = 1'b0;
  logic          reti = 1'b0;
  logic          irq_ack;
  logic [7:0]    irq_vec;
  logic [1:0]    cur_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icu_nest_top u_icu_nest_top (
    .clk(clk), .rst_n(rst_n), .src_flags(src_flags), .lvl_sel(lvl_sel),
    .gie(gie), .reti(reti), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .cur_level(cur_level)
  );

  // Reference model state
  int       m_lvl = 0;
  int       m_stk[$];
  bit       m_ack = 0;
  int       m_vec = 0;

  // R11 grouping, written from the requirement
  function automatic int slot_of(input int s);
    int sizes[NV] = '{1,1,3,2,1,2,2,3,3,3};
    int acc = 0;
    for (int v = 0; v < NV; v++) begin
      acc += sizes[v];
      if (s < acc) return v;
    end
    return -1;
  endfunction

  // R5 level of a pending slot
  function automatic int slot_level(input int v, input bit sel);
    if (!sel) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  task automatic model_step(input logic [NS-1:0] s, input logic [NV-1:0] ls,
                            input bit g, input bit r);
    int best_l = 0;
    int best_v = 0;
    bit pend[NV];
    for (int v = 0; v < NV; v++) pend[v] = 0;
    for (int i = 0; i < NS; i++) if (s[i]) pend[slot_of(i)] = 1;
    for (int v = NV - 1; v >= 0; v--)
      if (pend[v] && slot_level(v, ls[v]) >= best_l) begin
        best_l = slot_level(v, ls[v]);
        best_v = v;
      end
    m_ack = 0;
    if (r) begin
      m_lvl = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
    end else if (g && best_l > m_lvl) begin
      m_stk.push_back(m_lvl);
      m_lvl = best_l;
      m_ack = 1;
      m_vec = 8 * best_v + 3;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (irq_ack !== m_ack || int'(irq_vec) != m_vec || int'(cur_level) != m_lvl
        || $isunknown({irq_ack, irq_vec, cur_level})) begin
      errors++;
      $display("FAIL %s: ack=%0b vec=%02h lvl=%0d expected ack=%0b vec=%02h lvl=%0d",
               tag, irq_ack, irq_vec, cur_level, m_ack, m_vec[7:0], m_lvl);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic [NS-1:0] s, input logic [NV-1:0] ls,
                      input bit g, input bit r, input string tag);
    src_flags = s; lvl_sel = ls; gie = g; reti = r;
    model_step(s, ls, g, r);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1 reset state");

    // R11: bit 4 belongs to slot 2 -> 13h, low level
    step(21'h10, '0, 1, 0, "R11 shared source");
    step('0, '0, 1, 1, "R8 return to idle");
    // R8: return with nothing saved stays 0
    step('0, '0, 1, 1, "R8 empty return");
    // R4: slots 3 (bit 5) and 5 (bit 8) both low -> slot 3
    step(21'h120, '0, 1, 0, "R4 tie lowest slot");
    step('0, '0, 1, 1, "R8 pop");
    // R3/R5: slot 9 high vs slot 0 low -> slot 9, level 2
    step((21'd1 << 18) | 21'd1, 10'h200, 1, 0, "R3 higher level wins");
    // R7: slot 1 at top nests over high
    step((21'd1 << 18) | 21'd3, 10'h202, 1, 0, "R7 nested top");
    // R6: slot 0 at top while top in service -> nothing
    step((21'd1 << 18) | 21'd3, 10'h203, 1, 0, "R6 equal level refused");
    // R12: return with a pending acceptable request
    step(21'd1, 10'h001, 1, 1, "R12 reti wins");
    // R5: slot 2 with upper bit is high (2), not top
    step('0, '0, 1, 1, "R8 pop to idle");
    step(21'h4, 10'h004, 1, 0, "R5 high cap for slot 2");
    step('0, '0, 1, 1, "R8 pop");
    // R9: gie low blocks
    step(21'd1, 10'h001, 0, 0, "R9 gie low");
    step(21'd1, 10'h001, 1, 0, "R2 slot 0 address");
    step('0, '0, 1, 0, "R10 vector held");
    step('0, '0, 1, 1, "R8 pop");
    step(21'd1 << 20, '0, 1, 0, "R2 last slot address");
    step('0, '0, 1, 1, "R8 pop");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [NS-1:0] s;
      logic [NV-1:0] ls;
      bit g, r;
      string tag;
      s = '0;
      for (int i = 0; i < NS; i++) s[i] = ($urandom % 6 == 0);
      ls = NV'($urandom);
      g  = ($urandom % 8 != 0);
      r  = ($urandom % 4 == 0);
      tag = r ? "R8 random return" : (g ? "R3 random arbitration" : "R9 random disabled");
      step(s, ls, g, r, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule